// File: doc/BRIEF.md
# LCD Panel Sync Timing Generator

This block produces the horizontal sync, vertical sync and data-enable strobes for a parallel LCD panel. It runs on the pixel clock and keeps a pixel counter and a line counter, which it also drives out so that a downstream fetch engine can follow the raster. Software describes a frame through five 16-bit words: a horizontal count word, a horizontal sync word, a vertical total word, a vertical active word and a vertical sync word.

Every field in these words holds its value minus one. Horizontal quantities are given in characters of eight pixels, and vertical quantities are given in lines. A sync pulse begins at the end of the active region plus the front porch. The frame total is that start, plus the pulse width, plus the back porch.

The five words are sampled into a shadow copy only when a frame begins, so a write made mid-frame never splits a frame. Two polarity inputs select active-low syncs. A display-on input starts and stops the scan. A sticky frame-start flag, cleared by a write-one pulse and gated by an enable, forms the interrupt output.

Top module: `lcd_sync_gen`

## Requirements
- R1: `pix_x` counts from 0 to (T+1)*8-1 and then wraps to 0. T is `reg_hcount[7:0]`. The horizontal active size A-1, in characters, is held in `reg_hcount[15:8]`.
- R2: `line_y` advances by one at each pixel wrap, counts from 0 to `reg_vtotal`, and then wraps to 0.
- R3: `de` is 1 exactly when `pix_x/8 <= reg_hcount[15:8]` and `line_y <= reg_vactive` while scanning.
- R4: The horizontal sync pulse is active for character positions S+1 through S+W+1 of every line. S is `reg_hsync[11:0]` and W is `reg_hsync[15:12]`.
- R5: The vertical sync pulse is active for whole lines VS+1 through VS+VW+1. VS is `reg_vsync[11:0]` and VW is `reg_vsync[15:12]`.
- R6: When `hsync_low` (or `vsync_low`) is 1, the corresponding sync output is active-low; otherwise it is active-high. A change on these inputs applies immediately.
- R7: While `disp_on` is 0, both syncs sit at their inactive level, `de` is 0, both counters are 0, and the frame-start flag is never set.
- R8: When `disp_on` rises, the next cycle presents pixel 0 of line 0.
- R9: The timing words are captured only when a frame begins. A change written mid-frame leaves the rest of that frame unchanged and governs the next frame.
- R10: The frame-start flag becomes 1 on the first pixel of every frame. It stays 1 until a `vint_clr` pulse clears it. If a set and a clear fall on the same edge, the set wins.
- R11: `vint_irq` equals the flag ANDed with `vint_en`, and a disabled flag is still held.
- R12: After reset, the counters are 0, `de` is 0, `vint_irq` is 0, and the syncs show their inactive level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_hcount | input | 16 | Horizontal total and active size, in characters, each minus one |
| reg_hsync | input | 16 | Horizontal sync start (bits 11:0) and width (bits 15:12), in characters, each minus one |
| reg_vtotal | input | 16 | Total lines per frame minus one |
| reg_vactive | input | 16 | Active lines minus one |
| reg_vsync | input | 16 | Vertical sync start line (bits 11:0) and width (bits 15:12), each minus one |
| hsync_low | input | 1 | Horizontal sync active-low select |
| vsync_low | input | 1 | Vertical sync active-low select |
| disp_on | input | 1 | Scan enable; a rising edge restarts the frame |
| vint_en | input | 1 | Frame-start interrupt enable |
| vint_clr | input | 1 | Write-one pulse that clears the frame-start flag |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| de | output | 1 | Data enable |
| pix_x | output | 11 | Current pixel within the line |
| line_y | output | 16 | Current line within the frame |
| vint_irq | output | 1 | Frame-start interrupt |

## Verification
A corrupted pixel or line counter shows up on `pix_x` and `line_y` at the very next sample, and it shifts the `de` and sync windows within one line. A fault in the shadow capture appears only in the frame after a mid-frame write, so frame lengths and pulse counts are compared both across and within such a frame. A flag that sets on the wrong edge, or that loses the set-over-clear priority, is visible on `vint_irq` at the first pixel of the next frame.

// File: rtl/lcd_sync_pkg.sv
package lcd_sync_pkg;
    localparam int REG_W     = 16;
    localparam int CHAR_BITS = 3;
    localparam int HCH_W     = REG_W / 2;
    localparam int HSS_W     = 12;
    localparam int VSS_W     = 12;
    localparam int SW_W      = REG_W - HSS_W;
    localparam int LINE_W    = REG_W;
    localparam int PIX_W     = HCH_W + CHAR_BITS;

    typedef struct packed {
        logic [HCH_W-1:0]  h_total;
        logic [HCH_W-1:0]  h_active;
        logic [HSS_W-1:0]  h_sstart;
        logic [SW_W-1:0]   h_swidth;
        logic [LINE_W-1:0] v_total;
        logic [LINE_W-1:0] v_active;
        logic [VSS_W-1:0]  v_sstart;
        logic [SW_W-1:0]   v_swidth;
    } tcfg_t;

    typedef struct packed {
        logic              run;
        logic [PIX_W-1:0]  pix;
        logic [LINE_W-1:0] line;
    } scan_t;
endpackage

// File: rtl/lcd_cfg_shadow.sv
module lcd_cfg_shadow
    import lcd_sync_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [REG_W-1:0] hcount_reg,
    input  logic [REG_W-1:0] hsync_reg,
    input  logic [REG_W-1:0] vtotal_reg,
    input  logic [REG_W-1:0] vactive_reg,
    input  logic [REG_W-1:0] vsync_reg,
    input  logic             load_i,
    output tcfg_t            cfg_o
);
    tcfg_t decoded;
    tcfg_t cfg_d, cfg_q;

    always_comb begin
        decoded.h_total  = hcount_reg[HCH_W-1:0];
        decoded.h_active = hcount_reg[2*HCH_W-1:HCH_W];
        decoded.h_sstart = hsync_reg[HSS_W-1:0];
        decoded.h_swidth = hsync_reg[REG_W-1:HSS_W];
        decoded.v_total  = vtotal_reg[LINE_W-1:0];
        decoded.v_active = vactive_reg[LINE_W-1:0];
        decoded.v_sstart = vsync_reg[VSS_W-1:0];
        decoded.v_swidth = vsync_reg[REG_W-1:VSS_W];
        cfg_d = load_i ? decoded : cfg_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign cfg_o = cfg_o_drive();
    function automatic tcfg_t cfg_o_drive();
        return cfg_q;
    endfunction

    AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> $stable(cfg_q)); // R9
endmodule

// File: rtl/lcd_scan_ctr.sv
module lcd_scan_ctr
    import lcd_sync_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              disp_on_i,
    input  logic [HCH_W-1:0]  h_total_i,
    input  logic [LINE_W-1:0] v_total_i,
    output logic              run_o,
    output logic [PIX_W-1:0]  pix_o,
    output logic [LINE_W-1:0] line_o,
    output logic              frame_start_o
);
    scan_t st_d, st_q;
    logic [PIX_W-1:0] h_last;
    logic frame_start;

    always_comb begin
        h_last      = {h_total_i, {CHAR_BITS{1'b1}}};
        st_d        = st_q;
        frame_start = 1'b0;
        if (!disp_on_i) begin
            st_d = '0;
        end else if (!st_q.run) begin
            st_d.run    = 1'b1;
            st_d.pix    = '0;
            st_d.line   = '0;
            frame_start = 1'b1;
        end else if (st_q.pix == h_last) begin
            st_d.pix = '0;
            if (st_q.line == v_total_i) begin
                st_d.line   = '0;
                frame_start = 1'b1;
            end else begin
                st_d.line = st_q.line + 1'b1;
            end
        end else begin
            st_d.pix = st_q.pix + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign run_o         = st_q.run;
    assign pix_o         = st_q.pix;
    assign line_o        = st_q.line;
    assign frame_start_o = frame_start;

    AST_PIX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.run && disp_on_i && st_q.pix != h_last)
        |=> (st_q.pix == $past(st_q.pix) + 1'b1) && $stable(st_q.line)); // R1
    AST_PIX_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.run && disp_on_i && st_q.pix == h_last) |=> (st_q.pix == '0)); // R1
    AST_LINE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.run |-> (st_q.line <= v_total_i)); // R2
    AST_OFF_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !disp_on_i |=> (!st_q.run && st_q.pix == '0 && st_q.line == '0)); // R7
    AST_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (disp_on_i && !st_q.run) |=> (st_q.run && st_q.pix == '0 && st_q.line == '0)); // R8
endmodule

// File: rtl/lcd_window.sv
module lcd_window
    import lcd_sync_pkg::*;
#(
    parameter int POS_W   = 8,
    parameter int START_W = 12
) (
    input  logic [POS_W-1:0]   pos_i,
    input  logic [START_W-1:0] start_m1_i,
    input  logic [SW_W-1:0]    width_m1_i,
    output logic               in_o
);
    localparam int CMP_W = ((POS_W > START_W) ? POS_W : START_W) + 2;

    logic [CMP_W-1:0] p_ext, lo_ext, hi_ext;

    always_comb begin
        p_ext  = CMP_W'(pos_i);
        lo_ext = CMP_W'(start_m1_i);
        hi_ext = lo_ext + CMP_W'(width_m1_i) + CMP_W'(1);
        in_o   = (p_ext > lo_ext) && (p_ext <= hi_ext);
    end
endmodule

// File: rtl/lcd_vstart_flag.sv
module lcd_vstart_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    input  logic en_i,
    output logic irq_o
);
    logic flag_d, flag_q;

    always_comb begin
        flag_d = flag_q;
        if (clr_i) flag_d = 1'b0;
        if (set_i) flag_d = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flag_q <= 1'b0;
        else        flag_q <= flag_d;
    end

    assign irq_o = flag_q & en_i;

    AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> flag_q); // R10
    AST_FLAG_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !set_i) |=> !flag_q); // R10
    AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && !set_i) |=> $stable(flag_q)); // R10
endmodule

// File: rtl/lcd_sync_gen.sv
module lcd_sync_gen
    import lcd_sync_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [REG_W-1:0]  reg_hcount,
    input  logic [REG_W-1:0]  reg_hsync,
    input  logic [REG_W-1:0]  reg_vtotal,
    input  logic [REG_W-1:0]  reg_vactive,
    input  logic [REG_W-1:0]  reg_vsync,
    input  logic              hsync_low,
    input  logic              vsync_low,
    input  logic              disp_on,
    input  logic              vint_en,
    input  logic              vint_clr,
    output logic              hsync,
    output logic              vsync,
    output logic              de,
    output logic [PIX_W-1:0]  pix_x,
    output logic [LINE_W-1:0] line_y,
    output logic              vint_irq
);
    tcfg_t             cfg;
    logic              run;
    logic              frame_start;
    logic [PIX_W-1:0]  pix;
    logic [LINE_W-1:0] line;
    logic [HCH_W-1:0]  hchar;
    logic              h_in, v_in;

    lcd_cfg_shadow u_shadow (
        .clk         (clk),
        .rst_n       (rst_n),
        .hcount_reg  (reg_hcount),
        .hsync_reg   (reg_hsync),
        .vtotal_reg  (reg_vtotal),
        .vactive_reg (reg_vactive),
        .vsync_reg   (reg_vsync),
        .load_i      (frame_start),
        .cfg_o       (cfg)
    );

    lcd_scan_ctr u_scan (
        .clk           (clk),
        .rst_n         (rst_n),
        .disp_on_i     (disp_on),
        .h_total_i     (cfg.h_total),
        .v_total_i     (cfg.v_total),
        .run_o         (run),
        .pix_o         (pix),
        .line_o        (line),
        .frame_start_o (frame_start)
    );

    assign hchar = pix[PIX_W-1:CHAR_BITS];

    lcd_window #(.POS_W(HCH_W), .START_W(HSS_W)) u_hwin (
        .pos_i      (hchar),
        .start_m1_i (cfg.h_sstart),
        .width_m1_i (cfg.h_swidth),
        .in_o       (h_in)
    );

    lcd_window #(.POS_W(LINE_W), .START_W(VSS_W)) u_vwin (
        .pos_i      (line),
        .start_m1_i (cfg.v_sstart),
        .width_m1_i (cfg.v_swidth),
        .in_o       (v_in)
    );

    lcd_vstart_flag u_flag (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (frame_start),
        .clr_i (vint_clr),
        .en_i  (vint_en),
        .irq_o (vint_irq)
    );

    always_comb begin
        de     = run && (hchar <= cfg.h_active) && (line <= cfg.v_active);
        hsync  = (run && h_in) ^ hsync_low;
        vsync  = (run && v_in) ^ vsync_low;
        pix_x  = pix;
        line_y = line;
    end

    AST_DE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !disp_on |=> !de); // R7
    AST_SYNC_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !disp_on |=> (hsync == hsync_low && vsync == vsync_low)); // R7
endmodule

// File: tb/lcd_sync_gen_test.sv
module lcd_sync_gen_test;
    import lcd_sync_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int NV = 4;
    // fields: htot-1, hact-1, hss-1, hsw-1, vtot-1, vact-1, vss-1, vsw-1, hpol_low, vpol_low
    localparam int VEC [NV][10] = '{
        '{ 7, 3, 4, 0, 9, 5, 6, 1, 0, 0},
        '{ 9, 5, 6, 1, 7, 3, 4, 0, 1, 0},
        '{ 5, 1, 2, 2, 5, 2, 3, 1, 0, 1},
        '{11, 7, 8, 0, 4, 1, 2, 0, 1, 1}
    };

    logic clk = 1'b0;
    logic rst_n;
    logic [REG_W-1:0] reg_hcount, reg_hsync, reg_vtotal, reg_vactive, reg_vsync;
    logic hsync_low, vsync_low, disp_on, vint_en, vint_clr;
    logic hsync, vsync, de, vint_irq;
    logic [PIX_W-1:0] pix_x;
    logic [LINE_W-1:0] line_y;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;
    int first_x, first_y;

    always #(CLK_PERIOD/2) clk = ~clk;

    lcd_sync_gen uut (
        .clk(clk), .rst_n(rst_n),
        .reg_hcount(reg_hcount), .reg_hsync(reg_hsync), .reg_vtotal(reg_vtotal),
        .reg_vactive(reg_vactive), .reg_vsync(reg_vsync),
        .hsync_low(hsync_low), .vsync_low(vsync_low), .disp_on(disp_on),
        .vint_en(vint_en), .vint_clr(vint_clr),
        .hsync(hsync), .vsync(vsync), .de(de), .pix_x(pix_x), .line_y(line_y),
        .vint_irq(vint_irq)
    );

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic prog(input int k);
        reg_hcount  = {8'(VEC[k][1]), 8'(VEC[k][0])};
        reg_hsync   = {4'(VEC[k][3]), 12'(VEC[k][2])};
        reg_vtotal  = 16'(VEC[k][4]);
        reg_vactive = 16'(VEC[k][5]);
        reg_vsync   = {4'(VEC[k][7]), 12'(VEC[k][6])};
        hsync_low   = VEC[k][8][0];
        vsync_low   = VEC[k][9][0];
    endtask

    // Walks one full frame of configuration k starting at its first pixel sample.
    task automatic run_frame(input int k, input int chg, input bit clr_last);
        int t, a, s, w, vt, va, vs, vw, hpix, n, x, y;
        int bad_x, bad_y, bad_de, bad_hs, bad_vs;
        bit ede, ehs, evs;
        t = VEC[k][0]; a = VEC[k][1]; s = VEC[k][2]; w = VEC[k][3];
        vt = VEC[k][4]; va = VEC[k][5]; vs = VEC[k][6]; vw = VEC[k][7];
        hpix = (t + 1) * 8;
        n = hpix * (vt + 1);
        bad_x = 0; bad_y = 0; bad_de = 0; bad_hs = 0; bad_vs = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            x = i % hpix;
            y = i / hpix;
            if (i == 0) begin
                first_x = int'(pix_x);
                first_y = int'(line_y);
                check(vint_irq == 1'b1, "R10 flag set at first pixel", vint_irq, 1);
                vint_clr = 1'b0;
            end
            if (pix_x != x)  bad_x++;
            if (line_y != y) bad_y++;
            ede = (x / 8 <= a) && (y <= va);
            ehs = ((x / 8 >= s + 1) && (x / 8 <= s + w + 1)) ^ hsync_low;
            evs = ((y >= vs + 1) && (y <= vs + vw + 1)) ^ vsync_low;
            if (de !== ede)    bad_de++;
            if (hsync !== ehs) bad_hs++;
            if (vsync !== evs) bad_vs++;
            if (i == 52) check(vint_irq == 1'b0, "R10 flag cleared by pulse", vint_irq, 0);
            if (i == 50) vint_clr = 1'b1;
            if (i == 51) vint_clr = 1'b0;
            if (chg >= 0 && i == 100) prog(chg);
            if (clr_last && i == n - 1) vint_clr = 1'b1;
        end
        check(bad_x == 0,  "R1 pixel counter sequence", bad_x, 0);
        check(bad_y == 0,  "R2 line counter sequence", bad_y, 0);
        check(bad_de == 0, "R3 data enable window", bad_de, 0);
        check(bad_hs == 0, "R4 R6 hsync window and level", bad_hs, 0);
        check(bad_vs == 0, "R5 R6 vsync window and level", bad_vs, 0);
    endtask

    initial begin
        int bad_off;
        rst_n = 1'b0; disp_on = 1'b0; vint_en = 1'b0; vint_clr = 1'b0;
        reg_hcount = '0; reg_hsync = '0; reg_vtotal = '0; reg_vactive = '0; reg_vsync = '0;
        hsync_low = 1'b0; vsync_low = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12: reset state
        check(pix_x == 0 && line_y == 0, "R12 counters after reset", {pix_x, line_y}, 0);
        check(!de && !vint_irq && !hsync && !vsync, "R12 strobes after reset",
              {de, vint_irq, hsync, vsync}, 0);

        vint_en = 1'b1;
        // table walk: each configuration scanned for one frame (R1..R6, R10)
        for (int k = 0; k < NV; k++) begin
            @(negedge clk);
            disp_on = 1'b0;
            prog(k);
            @(negedge clk);
            disp_on = 1'b1;
            run_frame(k, -1, 1'b0);
        end

        // R9: mid-frame write, old frame intact, new frame uses new values.
        // R10: clear pulse on the last pixel collides with the set; set wins.
        @(negedge clk);
        disp_on = 1'b0;
        prog(0);
        @(negedge clk);
        disp_on = 1'b1;
        run_frame(0, 1, 1'b1);
        run_frame(1, -1, 1'b0);

        // R11: enable gates the output, flag is retained
        @(negedge clk);
        vint_en = 1'b0;
        @(negedge clk);
        check(vint_irq == 1'b0, "R11 irq masked by enable", vint_irq, 0);
        vint_en = 1'b1;
        @(negedge clk);
        check(vint_irq == 1'b1, "R11 flag retained while masked", vint_irq, 1);

        // R7: display off
        @(negedge clk);
        disp_on = 1'b0;
        prog(3);
        vint_clr = 1'b1;
        @(negedge clk);
        vint_clr = 1'b0;
        bad_off = 0;
        for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            if (hsync !== 1'b1 || vsync !== 1'b1 || de !== 1'b0 ||
                pix_x != 0 || line_y != 0 || vint_irq !== 1'b0) bad_off++;
        end
        check(bad_off == 0, "R7 outputs idle while display off", bad_off, 0);

        // R8: restart from mid-frame
        disp_on = 1'b1;
        repeat (37) @(negedge clk);
        disp_on = 1'b0;
        @(negedge clk);
        disp_on = 1'b1;
        run_frame(3, -1, 1'b0);
        check(first_x == 0 && first_y == 0, "R8 restart at pixel 0 line 0",
              first_x + first_y, 0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog R1 scan did not complete: actual 0 expected 1");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule